// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Static RAM

This block is a small synchronous static RAM that serves short bursts of four words. On a rising clock edge it samples an address, three chip-select inputs and the write controls. It can then return the addressed word in the cycle that follows, with no output register in the read path. Either of two active-low address strobes opens a burst. One strobe is meant for a processor and the other for a cache controller, and they differ in priority and in how they are gated by the selects. Later words of the burst come from a 2-bit counter that steps on an active-low advance input. The counter walks either a wrapping linear order or an XOR (interleaved) order, and the order is chosen by a level input that is captured when the burst opens.

A write covers one or more byte lanes. Each lane is `LANE_W` bits wide. With 9-bit lanes, bit 8 of each lane is that lane's parity bit, and the lane's own enable writes it along with the data. A global write input writes every lane. The read bus has a separate drive-enable output, which follows the asynchronous output-enable input with no clock involved. The surrounding logic uses this enable to tri-state the shared data pins.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset no burst is open, and `rdata_en` stays 0 until a read access has been opened.
- R2: When `cpu_start_n` is sampled low with all three selects true (`ce_n`=0, `ce2_p`=1, `ce2_n`=0), the sampled address opens a read. Through the following cycle `rdata` shows that word, with no extra register stage.
- R3: `ctl_start_n` sampled low with the selects true opens a burst at the sampled address. If any write enable is active in that edge, the word is written in that edge and the bus is not driven in the next cycle. Writes with advance continue at the next burst address.
- R4: `cpu_start_n` is ignored while `ce_n` is high, and the current burst carries on. When both strobes are valid, the processor strobe wins.
- R5: An edge in which the processor strobe opens an access is always a read, whatever the write enables are.
- R6: With `order_sel`=0 captured at the start, the n-th access (n=0..3) uses low address bits (start+n) mod 4. The upper bits stay fixed, and a fifth advance wraps back to the start.
- R7: With `order_sel`=1 captured at the start, the n-th access uses the starting low bits XOR n.
- R8: An edge with no valid strobe and `adv_n` high keeps the burst address unchanged.
- R9: `lane_wr_n[i]` low writes only lane i, bits [i*LANE_W +: LANE_W], including its parity bit 8. The other lanes keep their contents.
- R10: `all_wr_n` low writes every lane, whatever `lane_wr_n` is.
- R11: A strobe that is sampled while the selects are not all true closes the burst. No lane is written and the bus is not driven until the next valid strobe.
- R12: `rdata_en` is 1 only while `oe_n` is low and the current access is a read. It follows `oe_n` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| ce_n | input | 1 | Primary select, active low |
| ce2_p | input | 1 | Expansion select, active high |
| ce2_n | input | 1 | Expansion select, active low |
| cpu_start_n | input | 1 | Processor burst strobe, active low |
| ctl_start_n | input | 1 | Controller burst strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| all_wr_n | input | 1 | Global write, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data, lane i at [i*LANE_W +: LANE_W] |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_en | output | 1 | Bus drive enable |

## Verification
The assertions check on every clock the transitions of the burst register: a valid strobe clears the counter and loads the base address, an advance steps the counter by one, a hold leaves it unchanged, and a deselect closes the burst. They also check that the processor-strobe edge never enables a lane write. The bench scenarios are needed for the rest: the actual order of words in linear and interleaved bursts, lane isolation including parity bits, the global write override, and the writes suppressed after a deselect. The asynchronous response of the bus to `oe_n` can also only be seen in the bench. These behaviours show only in data read back later.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // per-edge decision from the strobe decoder
    typedef struct packed {
        logic load;     // valid strobe, selects true
        logic drop;     // strobe with selects false
        logic advance;  // step the burst counter
        logic write;    // this edge writes the array
    } burst_cmd_t;

    function automatic logic [1:0] burst_low(
        input logic [1:0]   first,
        input logic [1:0]   step,
        input burst_order_e order
    );
        if (order == ORDER_INTERLEAVED)
            return first ^ step;
        return first + step;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_n,
    input  logic             ce2_p,
    input  logic             ce2_n,
    input  logic             cpu_start_n,
    input  logic             ctl_start_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             all_wr_n,
    input  logic             active,
    output burst_cmd_t       cmd,
    output logic [LANES-1:0] lane_we
);

    logic cpu_go;
    logic ctl_go;
    logic start;
    logic selected;
    logic wr_req;
    logic live;

    always_comb begin
        cpu_go   = !cpu_start_n && !ce_n;
        ctl_go   = !ctl_start_n && !cpu_go;
        start    = cpu_go || ctl_go;
        selected = !ce_n && ce2_p && !ce2_n;
        wr_req   = !all_wr_n || !(&lane_wr_n);
        live     = (start && selected) || (!start && active);

        cmd.load    = start && selected;
        cmd.drop    = start && !selected;
        cmd.advance = !start && !adv_n && active;
        cmd.write   = live && wr_req && !cpu_go;

        if (!cmd.write)
            lane_we = '0;
        else if (!all_wr_n)
            lane_we = '1;
        else
            lane_we = ~lane_wr_n;
    end

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_t        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active,
    output logic              rd
);

    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;
    burst_order_e      mode_q, mode_d;
    logic              active_q, active_d;
    logic              rd_q;

    always_comb begin
        base_d   = base_q;
        cnt_d    = cnt_q;
        mode_d   = mode_q;
        active_d = active_q;
        if (cmd.load) begin
            base_d   = addr;
            cnt_d    = 2'd0;
            mode_d   = burst_order_e'(order_sel);
            active_d = 1'b1;
        end else if (cmd.drop) begin
            active_d = 1'b0;
        end else if (cmd.advance) begin
            cnt_d = cnt_q + 2'd1;
        end
    end

    // address used by the write at this edge, and the registered one for reads
    assign acc_addr = {base_d[ADDR_W-1:2], burst_low(base_d[1:0], cnt_d, mode_d)};
    assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, mode_q)};
    assign active   = active_q;
    assign rd       = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= 2'd0;
            mode_q   <= ORDER_LINEAR;
            active_q <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            base_q   <= base_d;
            cnt_q    <= cnt_d;
            mode_q   <= mode_d;
            active_q <= active_d;
            rd_q     <= active_d && !cmd.write;
        end
    end

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (cnt_q == 2'd0 && active_q && base_q == $past(addr)));

    // R6
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.advance |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !cmd.drop && !cmd.advance) |=> ($stable(cnt_q) && $stable(base_q)));

    // R11
    drop_close_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.drop |=> (!active_q && !rd_q));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // flow-through: no register between the array and the output
        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_n,
    input  logic                    ce2_p,
    input  logic                    ce2_n,
    input  logic                    cpu_start_n,
    input  logic                    ctl_start_n,
    input  logic                    adv_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    all_wr_n,
    input  logic                    order_sel,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);

    localparam int DATA_W = LANES * LANE_W;

    burst_cmd_t        cmd;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic              active;
    logic              rd;
    logic [DATA_W-1:0] arr_q;

    bsram_ctrl #(.LANES(LANES)) i_ctrl (
        .ce_n        (ce_n),
        .ce2_p       (ce2_p),
        .ce2_n       (ce2_n),
        .cpu_start_n (cpu_start_n),
        .ctl_start_n (ctl_start_n),
        .adv_n       (adv_n),
        .lane_wr_n   (lane_wr_n),
        .all_wr_n    (all_wr_n),
        .active      (active),
        .cmd         (cmd),
        .lane_we     (lane_we)
    );

    bsram_burst #(.ADDR_W(ADDR_W)) i_burst (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .addr      (addr),
        .order_sel (order_sel),
        .acc_addr  (acc_addr),
        .cur_addr  (cur_addr),
        .active    (active),
        .rd        (rd)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (acc_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (arr_q)
    );

    assign rdata_en = rd && !oe_n;
    assign rdata    = rdata_en ? arr_q : '0;

    // R5
    cpu_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_start_n && !ce_n) |-> (lane_we == '0));

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int AW    = 6;
    localparam int LN    = 2;
    localparam int LW    = 9;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          ce_n, ce2_p, ce2_n;
    logic          cpu_start_n, ctl_start_n, adv_n;
    logic [LN-1:0] lane_wr_n;
    logic          all_wr_n, order_sel, oe_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .ce2_p(ce2_p), .ce2_n(ce2_n),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
        .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n), .order_sel(order_sel),
        .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state derived from the requirements
    logic [DW-1:0] m_mem [DEPTH];
    logic          m_active, m_rd, m_mode;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 32'h1357) ^ 32'h2A5C3);
    endfunction

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = m_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit cpu, ctl, st, sel, wr;
        cpu = !cpu_start_n && !ce_n;
        ctl = !ctl_start_n && !cpu;
        st  = cpu || ctl;
        sel = !ce_n && ce2_p && !ce2_n;
        wr  = (!all_wr_n || (lane_wr_n != '1)) && !cpu;
        if (st && sel) begin
            m_base = addr; m_cnt = 2'd0; m_mode = order_sel; m_active = 1'b1;
        end else if (st) begin
            m_active = 1'b0;
        end else if (!adv_n && m_active) begin
            m_cnt = m_cnt + 2'd1;
        end
        if (m_active && wr) begin
            for (int l = 0; l < LN; l++)
                if (!all_wr_n || !lane_wr_n[l])
                    m_mem[m_addr()][l*LW +: LW] = wdata[l*LW +: LW];
        end
        m_rd = m_active && !(m_active && wr);
    endtask

    // one clock; model update; compare the flow-through output after the edge
    task automatic cyc(input string tag);
        bit exp_en;
        @(posedge clk);
        model_edge();
        #1;
        exp_en = m_rd && !oe_n;
        chk(rdata_en == exp_en, tag, 32'(rdata_en), 32'(exp_en));
        if (exp_en)
            chk(rdata == m_mem[m_addr()], tag, 32'(rdata), 32'(m_mem[m_addr()]));
    endtask

    // explicit expected word, independent of the model's address logic
    task automatic expect_word(input string tag, input logic [DW-1:0] exp);
        chk(rdata_en == 1'b1, tag, 32'(rdata_en), 32'd1);
        chk(rdata == exp, tag, 32'(rdata), 32'(exp));
    endtask

    task automatic idle();
        ce_n = 1'b0; ce2_p = 1'b1; ce2_n = 1'b0;
        cpu_start_n = 1'b1; ctl_start_n = 1'b1; adv_n = 1'b1;
        lane_wr_n = '1; all_wr_n = 1'b1; oe_n = 1'b0;
    endtask

    task automatic cpu_read(input int a, input bit ord, input string tag);
        idle(); addr = AW'(a); order_sel = ord; cpu_start_n = 1'b0;
        cyc(tag);
        idle();
    endtask

    task automatic advance(input string tag);
        idle(); adv_n = 1'b0;
        cyc(tag);
        idle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle(); addr = '0; order_sel = 1'b0; wdata = '0;
        m_active = 1'b0; m_rd = 1'b0; m_mode = 1'b0; m_base = '0; m_cnt = 2'd0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1
        chk(rdata_en == 1'b0, "R1", 32'(rdata_en), 32'd0);
        cyc("R1");
        chk(rdata_en == 1'b0, "R1", 32'(rdata_en), 32'd0);

        // preload every word with a global write through the controller strobe
        for (int a = 0; a < DEPTH; a++) begin
            idle(); addr = AW'(a); ctl_start_n = 1'b0; all_wr_n = 1'b0; wdata = pat(a);
            cyc("R10");
        end
        idle();

        // R2 flow-through read
        cpu_read(5, 1'b0, "R2");
        expect_word("R2", pat(5));

        // R6 linear from low bits 01: 9,10,11,8 then wrap to 9
        cpu_read(9, 1'b0, "R6");
        expect_word("R6", pat(9));
        advance("R6"); expect_word("R6", pat(10));
        advance("R6"); expect_word("R6", pat(11));
        advance("R6"); expect_word("R6", pat(8));
        advance("R6"); expect_word("R6", pat(9));

        // R7 interleaved from low bits 01: 13,12,15,14
        cpu_read(13, 1'b1, "R7");
        expect_word("R7", pat(13));
        advance("R7"); expect_word("R7", pat(12));
        advance("R7"); expect_word("R7", pat(15));
        advance("R7"); expect_word("R7", pat(14));

        // R8 hold
        idle(); cyc("R8"); expect_word("R8", pat(14));
        idle(); cyc("R8"); expect_word("R8", pat(14));

        // R12 asynchronous output enable
        oe_n = 1'b1; #1;
        chk(rdata_en == 1'b0, "R12", 32'(rdata_en), 32'd0);
        chk(rdata == '0, "R12", 32'(rdata), 32'd0);
        oe_n = 1'b0; #1;
        expect_word("R12", pat(14));

        // R4 processor strobe ignored while primary select is high
        idle(); ce_n = 1'b1; cpu_start_n = 1'b0; addr = AW'(20);
        cyc("R4");
        idle(); #1;
        expect_word("R4", pat(14));

        // R4/R5 both strobes with writes: processor wins, edge is a read
        idle(); cpu_start_n = 1'b0; ctl_start_n = 1'b0; addr = AW'(21);
        all_wr_n = 1'b0; lane_wr_n = '0; wdata = '1;
        cyc("R5");
        idle(); #1;
        expect_word("R5", pat(21));

        // R3 controller write burst: 44 then 45
        idle(); ctl_start_n = 1'b0; addr = AW'(44); order_sel = 1'b0;
        all_wr_n = 1'b0; wdata = DW'(18'h1_2345);
        cyc("R3");
        chk(rdata_en == 1'b0, "R3", 32'(rdata_en), 32'd0);
        idle(); adv_n = 1'b0; all_wr_n = 1'b0; wdata = DW'(18'h2_0F0F);
        cyc("R3");
        idle();
        cpu_read(44, 1'b0, "R3"); expect_word("R3", DW'(18'h1_2345));
        advance("R3");            expect_word("R3", DW'(18'h2_0F0F));

        // R9 lane a only, including its parity bit
        idle(); ctl_start_n = 1'b0; addr = AW'(30); lane_wr_n = 2'b10; wdata = '1;
        cyc("R9");
        cpu_read(30, 1'b0, "R9");
        expect_word("R9", {pat(30)[17:9], 9'h1FF});
        idle(); ctl_start_n = 1'b0; addr = AW'(32); lane_wr_n = 2'b01; wdata = '0;
        cyc("R9");
        cpu_read(32, 1'b0, "R9");
        expect_word("R9", {9'h000, pat(32)[8:0]});

        // R10 global write overrides lane enables
        idle(); ctl_start_n = 1'b0; addr = AW'(31); all_wr_n = 1'b0; lane_wr_n = '1;
        wdata = DW'(18'h2_AAAA);
        cyc("R10");
        cpu_read(31, 1'b0, "R10");
        expect_word("R10", DW'(18'h2_AAAA));

        // R11 deselect via second positive select, then attempted writes
        idle(); ctl_start_n = 1'b0; ce2_p = 1'b0; addr = AW'(40);
        all_wr_n = 1'b0; wdata = '0;
        cyc("R11");
        chk(rdata_en == 1'b0, "R11", 32'(rdata_en), 32'd0);
        idle(); adv_n = 1'b0; all_wr_n = 1'b0; wdata = '0;
        cyc("R11");
        chk(rdata_en == 1'b0, "R11", 32'(rdata_en), 32'd0);
        idle(); ctl_start_n = 1'b0; ce2_n = 1'b1; addr = AW'(41); all_wr_n = 1'b0;
        cyc("R11");
        cpu_read(40, 1'b0, "R11"); expect_word("R11", pat(40));
        cpu_read(41, 1'b0, "R11"); expect_word("R11", pat(41));

        // constrained random traffic against the reference state
        for (int i = 0; i < 4000; i++) begin
            addr        = AW'($urandom_range(DEPTH - 1, 0));
            ce_n        = ($urandom_range(99, 0) < 10);
            ce2_p       = ($urandom_range(99, 0) < 92);
            ce2_n       = ($urandom_range(99, 0) < 8);
            cpu_start_n = ($urandom_range(99, 0) >= 15);
            ctl_start_n = ($urandom_range(99, 0) >= 15);
            adv_n       = ($urandom_range(99, 0) >= 50);
            lane_wr_n   = ($urandom_range(99, 0) < 30) ? LN'($urandom) : '1;
            all_wr_n    = ($urandom_range(99, 0) >= 10);
            order_sel   = 1'($urandom);
            oe_n        = ($urandom_range(99, 0) < 20);
            wdata       = DW'($urandom);
            cyc("R12");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule